// File: doc/BRIEF.md
# Data-Memory Pointer Unit

This unit holds the pointer that a small 4-bit controller uses to reach its data memory. The pointer is split into a register-select field and a digit field. The data memory holds four registers of eight 4-bit digits. Each cycle the instruction decoder presents one pointer operation on `op_code`, together with its operands. Possible updates are an immediate load, an XOR of the register field, a step of the digit field up or down, a copy from the accumulator, or a temporary redirect to a fixed cell. The unit then drives the memory address and a skip pulse that the sequencer uses to skip the next instruction.

The digit field is one bit wider than the digit index that reaches the memory, so two field values select each physical digit. The skip pulse marks only a wrap of the whole digit field. It ignores the carry into the unused top bit. Operations arrive one per cycle with no handshake. The decoder always supplies an operation, `OP_NOP` included, and the unit accepts it in that cycle, so there is no back-pressure.

Top module: `ptr_unit`

## Requirements
- R1: While `rst_n` is low, the register field and the digit field both clear to 0 on the next rising edge. After reset, `ram_addr` reads 0 and `skip` reads 0 when no operation is presented.
- R2: Outside `OP_FIXED`, `ram_addr[4:3]` equals the register field and `ram_addr[2:0]` equals the low 3 bits of the digit field. The top digit bit has no effect, so digit values d and d+8 give the same address.
- R3: `OP_LOAD` (code 1) sets the register field to `op_r` and the digit field to `op_imm`+1 modulo 16. An immediate of 15 loads 0, and an immediate of 8 loads 9.
- R4: `OP_XREG` (code 2) replaces the register field with its XOR with `op_r` and leaves the digit field unchanged.
- R5: `OP_INC` (code 3) adds 1 to the digit field and XORs the register field with `op_r`. `skip` is 1 in that cycle only when the digit field was 15.
- R6: `OP_DEC` (code 4) subtracts 1 from the digit field and XORs the register field with `op_r`. `skip` is 1 in that cycle only when the digit field was 0. A step between 8 and 7 gives no skip.
- R7: `OP_STORE` (code 5) adds 1 to the digit field and leaves the register field unchanged. `skip` stays 0, even on the wrap from 15 to 0. Any operation other than codes 3 and 4 leaves `skip` at 0.
- R8: `OP_ACC` (code 6) loads the digit field from `acc_in`. `ptr_digit` always presents the full 4-bit digit field so that it can be copied back to the accumulator.
- R9: `OP_FIXED` (code 7) drives `ram_addr` to register 3, digit 15 (address 31) in that cycle, whatever the pointer holds, and leaves the pointer unchanged.
- R10: `OP_NOP` (code 0) leaves the pointer unchanged.
- R11: An update presented in a cycle becomes visible on `ptr_reg`, `ptr_digit` and `ram_addr` only after the next rising edge. Until that edge, the outputs show the old pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Pointer operation for this cycle |
| op_r | input | 2 | Register-field operand (load value or XOR mask) |
| op_imm | input | 4 | Digit immediate, encoded as value minus one |
| acc_in | input | 4 | Accumulator value for `OP_ACC` |
| ram_addr | output | 5 | Data-memory cell address {register, digit[2:0]} |
| ptr_reg | output | 2 | Current register field |
| ptr_digit | output | 4 | Current digit field, full width |
| skip | output | 1 | Skip pulse for a wrapping step |

## Verification
The bench builds the unit with its default parameters: a 2-bit register field, a 4-bit digit field and 3 digit-index bits, with the fixed cell at register 3, digit 15. With a 16-value digit field, both wraps can be reached from a single load, and so can the 7/8 boundary where the unused top bit toggles. That makes it possible to show that a skip comes only from a full wrap and that aliased digit values share one address. The 2-bit register field lets every XOR mask be observed at the ports.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_XREG  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4,
    OP_STORE = 3'd5,
    OP_ACC   = 3'd6,
    OP_FIXED = 3'd7
  } ptr_op_e;
endpackage

// File: rtl/ptr_skip.sv
module ptr_skip
  import ptr_pkg::*;
#(
  parameter int DIG_W = 4
) (
  input  ptr_op_e          op,
  input  logic [DIG_W-1:0] cur_dig,
  output logic             skip
);
  localparam logic [DIG_W-1:0] DIG_TOP = '1;
  localparam logic [DIG_W-1:0] DIG_BOT = '0;

  // Only a wrap of the whole field counts; carries into the unused top bit do not.
  always_comb begin
    unique case (op)
      OP_INC:  skip = (cur_dig == DIG_TOP);
      OP_DEC:  skip = (cur_dig == DIG_BOT);
      default: skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptr_next.sv
module ptr_next
  import ptr_pkg::*;
#(
  parameter int REG_W = 2,
  parameter int DIG_W = 4
) (
  input  ptr_op_e          op,
  input  logic [REG_W-1:0] cur_reg,
  input  logic [DIG_W-1:0] cur_dig,
  input  logic [REG_W-1:0] opr_r,
  input  logic [DIG_W-1:0] imm,
  input  logic [DIG_W-1:0] acc,
  output logic [REG_W-1:0] nxt_reg,
  output logic [DIG_W-1:0] nxt_dig
);
  localparam logic [DIG_W-1:0] ONE = DIG_W'(1);

  logic [DIG_W-1:0] dig_up;
  logic [DIG_W-1:0] dig_dn;
  logic [REG_W-1:0] reg_x;

  assign dig_up = cur_dig + ONE;
  assign dig_dn = cur_dig - ONE;
  assign reg_x  = cur_reg ^ opr_r;

  always_comb begin
    nxt_reg = cur_reg;
    nxt_dig = cur_dig;
    unique case (op)
      OP_LOAD: begin
        nxt_reg = opr_r;
        nxt_dig = imm + ONE;
      end
      OP_XREG:  nxt_reg = reg_x;
      OP_INC: begin
        nxt_reg = reg_x;
        nxt_dig = dig_up;
      end
      OP_DEC: begin
        nxt_reg = reg_x;
        nxt_dig = dig_dn;
      end
      OP_STORE: nxt_dig = dig_up;
      OP_ACC:   nxt_dig = acc;
      default: begin
        nxt_reg = cur_reg;
        nxt_dig = cur_dig;
      end
    endcase
  end
endmodule

// File: rtl/ptr_addr_map.sv
module ptr_addr_map
  import ptr_pkg::*;
#(
  parameter int REG_W   = 2,
  parameter int DIG_W   = 4,
  parameter int CELL_W  = 3,
  parameter int FIX_REG = 3,
  parameter int FIX_DIG = 15,
  localparam int ADDR_W = REG_W + CELL_W
) (
  input  ptr_op_e           op,
  input  logic [REG_W-1:0]  cur_reg,
  input  logic [DIG_W-1:0]  cur_dig,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [REG_W-1:0] FREG = REG_W'(FIX_REG);
  localparam logic [DIG_W-1:0] FDIG = DIG_W'(FIX_DIG);

  logic [CELL_W-1:0] cell_cur;
  logic [CELL_W-1:0] cell_fix;

  generate
    if (CELL_W < DIG_W) begin : g_alias
      assign cell_cur = cur_dig[CELL_W-1:0];
      assign cell_fix = FDIG[CELL_W-1:0];
    end else begin : g_full
      assign cell_cur = CELL_W'(cur_dig);
      assign cell_fix = CELL_W'(FDIG);
    end
  endgenerate

  always_comb begin
    if (op == OP_FIXED) addr = {FREG, cell_fix};
    else                addr = {cur_reg, cell_cur};
  end
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
  import ptr_pkg::*;
#(
  parameter int REG_W   = 2,
  parameter int DIG_W   = 4,
  parameter int CELL_W  = 3,
  parameter int FIX_REG = 3,
  parameter int FIX_DIG = 15,
  localparam int ADDR_W = REG_W + CELL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic [REG_W-1:0]  op_r,
  input  logic [DIG_W-1:0]  op_imm,
  input  logic [DIG_W-1:0]  acc_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [REG_W-1:0]  ptr_reg,
  output logic [DIG_W-1:0]  ptr_digit,
  output logic              skip
);
  ptr_op_e          op;
  logic [REG_W-1:0] reg_q, reg_d;
  logic [DIG_W-1:0] dig_q, dig_d;

  assign op = ptr_op_e'(op_code);

  ptr_next #(.REG_W(REG_W), .DIG_W(DIG_W)) u_next (
    .op(op), .cur_reg(reg_q), .cur_dig(dig_q), .opr_r(op_r),
    .imm(op_imm), .acc(acc_in), .nxt_reg(reg_d), .nxt_dig(dig_d)
  );

  ptr_skip #(.DIG_W(DIG_W)) u_skip (
    .op(op), .cur_dig(dig_q), .skip(skip)
  );

  ptr_addr_map #(
    .REG_W(REG_W), .DIG_W(DIG_W), .CELL_W(CELL_W),
    .FIX_REG(FIX_REG), .FIX_DIG(FIX_DIG)
  ) u_map (
    .op(op), .cur_reg(reg_q), .cur_dig(dig_q), .addr(ram_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= '0;
      dig_q <= '0;
    end else begin
      reg_q <= reg_d;
      dig_q <= dig_d;
    end
  end

  assign ptr_reg   = reg_q;
  assign ptr_digit = dig_q;
endmodule

// File: rtl/ptr_unit_chk.sv
module ptr_unit_chk #(
  parameter int REG_W   = 2,
  parameter int DIG_W   = 4,
  parameter int CELL_W  = 3,
  parameter int FIX_REG = 3,
  parameter int FIX_DIG = 15,
  localparam int ADDR_W = REG_W + CELL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        op_code,
  input logic [REG_W-1:0]  op_r,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [REG_W-1:0]  ptr_reg,
  input logic [DIG_W-1:0]  ptr_digit,
  input logic              skip
);
  localparam logic [DIG_W-1:0] ONE = DIG_W'(1);
  localparam logic [ADDR_W-1:0] FIX_ADDR =
    {REG_W'(FIX_REG), CELL_W'(FIX_DIG)};

  assert_skip_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (op_code == 3'd3 || op_code == 3'd4));

  assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd3 && skip) |=> (ptr_digit == '0));

  assert_dec_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd4 && skip) |=> (ptr_digit == '1));

  assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd3) |=> (ptr_digit == $past(ptr_digit) + ONE &&
                           ptr_reg == ($past(ptr_reg) ^ $past(op_r))));

  assert_dec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd4) |=> (ptr_digit == $past(ptr_digit) - ONE &&
                           ptr_reg == ($past(ptr_reg) ^ $past(op_r))));

  assert_fixed_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd7) |-> (ram_addr == FIX_ADDR));

  assert_fixed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd7) |=> ($stable(ptr_reg) && $stable(ptr_digit)));

  assert_nop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0) |=> ($stable(ptr_reg) && $stable(ptr_digit)));
endmodule

bind ptr_unit ptr_unit_chk #(
  .REG_W(REG_W), .DIG_W(DIG_W), .CELL_W(CELL_W),
  .FIX_REG(FIX_REG), .FIX_DIG(FIX_DIG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_r(op_r),
  .ram_addr(ram_addr), .ptr_reg(ptr_reg), .ptr_digit(ptr_digit),
  .skip(skip)
);

// File: tb/sim_ptr_unit.sv
module sim_ptr_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [1:0] op_r = 2'd0;
  logic [3:0] op_imm = 4'd0;
  logic [3:0] acc_in = 4'd0;
  logic [4:0] ram_addr;
  logic [1:0] ptr_reg;
  logic [3:0] ptr_digit;
  logic       skip;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ptr_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_r(op_r),
    .op_imm(op_imm), .acc_in(acc_in), .ram_addr(ram_addr),
    .ptr_reg(ptr_reg), .ptr_digit(ptr_digit), .skip(skip)
  );

  // row: op, r, imm, acc, expected reg after, expected digit after, expected skip
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {3'd1, 2'd2, 4'd15, 4'd0,  2'd2, 4'd0,  1'b0},  // R3 imm 15 -> 0
    {3'd4, 2'd0, 4'd0,  4'd0,  2'd2, 4'd15, 1'b1},  // R6 wrap 0 -> 15
    {3'd3, 2'd1, 4'd0,  4'd0,  2'd3, 4'd0,  1'b1},  // R5 wrap 15 -> 0
    {3'd1, 2'd1, 4'd6,  4'd0,  2'd1, 4'd7,  1'b0},  // R3
    {3'd3, 2'd0, 4'd0,  4'd0,  2'd1, 4'd8,  1'b0},  // R5 7 -> 8 no skip
    {3'd4, 2'd0, 4'd0,  4'd0,  2'd1, 4'd7,  1'b0},  // R6 8 -> 7 no skip
    {3'd2, 2'd3, 4'd0,  4'd0,  2'd2, 4'd7,  1'b0},  // R4
    {3'd6, 2'd0, 4'd0,  4'd15, 2'd2, 4'd15, 1'b0},  // R8
    {3'd5, 2'd1, 4'd0,  4'd0,  2'd2, 4'd0,  1'b0},  // R7 wrap, no skip
    {3'd6, 2'd0, 4'd0,  4'd9,  2'd2, 4'd9,  1'b0},  // R8
    {3'd7, 2'd3, 4'd3,  4'd3,  2'd2, 4'd9,  1'b0},  // R9
    {3'd0, 2'd3, 4'd3,  4'd3,  2'd2, 4'd9,  1'b0},  // R10
    {3'd3, 2'd2, 4'd0,  4'd0,  2'd0, 4'd10, 1'b0}   // R5
  };

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [1:0] r,
                       input logic [3:0] im, input logic [3:0] a);
    @(negedge clk);
    op_code = o; op_r = r; op_imm = im; acc_in = a;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] m_reg;
    logic [3:0] m_dig;
    logic [3:0] a_lo;
    repeat (3) @(posedge clk);
    #1;
    check("R1", ptr_reg, 0, "reset reg");
    check("R1", ptr_digit, 0, "reset digit");
    check("R1", ram_addr, 0, "reset addr");
    check("R1", skip, 0, "reset skip");
    @(negedge clk);
    rst_n = 1'b1;
    m_reg = 2'd0;
    m_dig = 4'd0;

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      drive(v[19:17], v[16:15], v[14:11], v[10:7]);
      #2;
      check("R5/R6/R7", skip, v[0], $sformatf("skip vec %0d", i));
      if (v[19:17] == 3'd7)
        check("R9", ram_addr, 31, $sformatf("fixed addr vec %0d", i));
      else
        check("R2", ram_addr, {m_reg, m_dig[2:0]}, $sformatf("addr vec %0d", i));
      check("R11", ptr_digit, m_dig, $sformatf("old digit vec %0d", i));
      @(posedge clk);
      #1;
      check("R3-R10 reg", ptr_reg, v[6:5], $sformatf("reg vec %0d", i));
      check("R3-R10 dig", ptr_digit, v[4:1], $sformatf("digit vec %0d", i));
      m_reg = v[6:5];
      m_dig = v[4:1];
    end

    // R2 alias: digit 3 and digit 11 hit the same cell
    drive(3'd1, 2'd1, 4'd2, 4'd0);
    drive(3'd0, 2'd0, 4'd0, 4'd0);
    #2;
    a_lo = 4'(ram_addr);
    check("R2", ram_addr, 5'd11, "addr digit 3 reg 1");
    drive(3'd6, 2'd0, 4'd0, 4'd11);
    drive(3'd0, 2'd0, 4'd0, 4'd0);
    #2;
    check("R8", ptr_digit, 11, "acc load keeps top bit");
    check("R2", ram_addr, 5'(a_lo), "alias d+8 same addr");

    // R3 immediate 8 loads 9
    drive(3'd1, 2'd0, 4'd8, 4'd0);
    drive(3'd0, 2'd0, 4'd0, 4'd0);
    #2;
    check("R3", ptr_digit, 9, "imm 8 -> 9");

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1", ptr_digit, 0, "mid reset digit");
    check("R1", ptr_reg, 0, "mid reset reg");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule